// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block keeps a bank of event counters for a network MAC: octet totals, frame totals by kind, error counts and similar. Each counter advances on a one-cycle pulse from the datapath. Octet counters add a byte count that comes with the pulse. Frame counters add one. Frame parsing and classification happen upstream. This block only counts.

Software reads the counters through a 16-bit register port. First it writes the snapshot command. That command copies every live counter into its own holding register on one clock edge, so a whole set of values read afterwards is mutually consistent. Each counter is 40 bits wide and is read as three 16-bit words.

When a counter wraps past its maximum, it sets a sticky flag. The flags are gathered into four 16-bit registers that clear when read, so software can rebuild counts wider than 40 bits. A clear command zeroes every live counter at once.

Top module: `stat_snapshot_bank`

## Requirements
- R1: Each counter is CNT_W bits wide, 40 by default. A counter listed in OCTET_MASK adds its evt_amt lane (0 to 16) when its evt_inc bit is high. Any other counter adds exactly one, whatever its evt_amt lane holds.
- R2: Counter i is read at address 0x10 + 4*i. Word offset k (0, 1 or 2) returns bits 16k+15:16k of its holding register, with zeros above bit CNT_W-1. With 40 bits the words carry 16, 16 and 8 bits.
- R3: A write to address 0x00 with data bit 0 set copies every live counter into its holding register on that clock edge. An increment in the same cycle is not part of the copy. Counter reads return only holding values.
- R4: A write to address 0x00 with data bit 1 set zeroes every live counter. Increments in that cycle are discarded. Holding registers and rollover flags keep their values. If bit 0 is also set, the copy takes the values from before the clear.
- R5: An increment that carries a counter past 2^CNT_W - 1 leaves the counter holding the sum modulo 2^CNT_W and sets rollover flag i, where i is the counter's index.
- R6: Rollover register j at address 0x04 + j (j = 0 to 3) shows flags 16j to 16j+15, with bit b standing for counter 16j+b. Reading it returns the flags and clears them. Bits for counters that do not exist read as zero.
- R7: A wrap in the same cycle as the clearing read of its register is not lost. That read returns the earlier flags, and the new flag stays set for the next read.
- R8: Reads of unmapped addresses return zero. This covers the control register, word offset 3 of each counter, addresses past the last counter and any other unassigned address.
- R9: reg_rdata changes only on the cycle after reg_rd is high, and holds its value otherwise.
- R10: After reset, live counters, holding registers, rollover flags and reg_rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_inc | input | NUM_CNT | One increment pulse per counter |
| evt_amt | input | NUM_CNT*AMT_W | Byte count per counter, lane i at bits i*AMT_W and up |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, valid one cycle after reg_rd |

## Verification
The bench builds the bank with six counters of 18 bits each, counters 0 and 1 counting octets. At 16 bytes per cycle a counter wraps after 16384 cycles, so both wrap cases can be reached directly: the plain wrap, and the wrap that coincides with the clearing read of its register. With six counters, every counter, every word offset and every address that falls just outside the map can be swept. The split across the second and third words is checked with zero fill above bit 17.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int REG_W      = 16;
    localparam int CNT_WORDS  = 3;
    localparam int PAD_W      = CNT_WORDS * REG_W;
    localparam int FLAG_REGS  = 4;
    localparam int FLAG_BITS  = FLAG_REGS * REG_W;
    localparam int CTRL_ADDR  = 0;
    localparam int FLAG_BASE  = 4;
    localparam int CNT_BASE   = 16;
    localparam int CNT_STRIDE = 4;
    localparam int SNAP_BIT   = 0;
    localparam int CLR_BIT    = 1;

    typedef struct packed {
        logic                 snap;
        logic                 clr;
        logic [FLAG_REGS-1:0] flag_rd;
    } cmd_t;
endpackage

// File: rtl/stat_ctr.sv
module stat_ctr #(
    parameter int CNT_W    = 40,
    parameter int AMT_W    = 5,
    parameter bit IS_OCTET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             snap,
    input  logic             inc,
    input  logic [AMT_W-1:0] amt,
    output logic [CNT_W-1:0] hold,
    output logic             wrap
);
    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] live;
        logic [CNT_W-1:0] hold;
    } ctr_st_t;

    ctr_st_t    s_d, s_q;
    logic [SUM_W-1:0] step;
    logic [SUM_W-1:0] sum;

    generate
        if (IS_OCTET) begin : g_octet
            assign step = SUM_W'(amt);
        end else begin : g_frame
            logic unused_amt;
            assign unused_amt = ^amt;
            assign step = SUM_W'(1);
        end
    endgenerate

    always_comb begin
        s_d  = s_q;
        sum  = {1'b0, s_q.live} + step;
        wrap = 1'b0;
        if (snap) begin
            s_d.hold = s_q.live;
        end
        if (clr) begin
            s_d.live = '0;
        end else if (inc) begin
            s_d.live = sum[CNT_W-1:0];
            wrap     = sum[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold = s_q.hold;

    a_r3_snap_copies_live: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (s_q.hold == $past(s_q.live)));
    a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.live == '0));
    a_r5_wrap_goes_lower: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (s_q.live < $past(s_q.live)));
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(s_q.hold));
endmodule

// File: rtl/stat_flags.sv
module stat_flags
    import stat_pkg::*;
#(
    parameter int NUM_CNT = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CNT-1:0]   wrap,
    input  logic [FLAG_REGS-1:0] flag_rd,
    output logic [FLAG_BITS-1:0] flags
);
    typedef struct packed {
        logic [NUM_CNT-1:0] bits;
    } flag_st_t;

    flag_st_t           s_d, s_q;
    logic [NUM_CNT-1:0] clr_mask;

    always_comb begin
        for (int i = 0; i < NUM_CNT; i++) begin
            clr_mask[i] = flag_rd[i / REG_W];
        end
        s_d.bits = (s_q.bits & ~clr_mask) | wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags = FLAG_BITS'(s_q.bits);

    a_r7_wrap_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> ((s_q.bits & $past(wrap)) == $past(wrap)));
    a_r6_set_only_by_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.bits & ~$past(s_q.bits) & ~$past(wrap)) == '0));
endmodule

// File: rtl/stat_regif.sv
module stat_regif
    import stat_pkg::*;
#(
    parameter int NUM_CNT = 24,
    parameter int CNT_W   = 40,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr,
    input  logic [REG_W-1:0]         wdata,
    input  logic                     rd,
    input  logic [NUM_CNT*CNT_W-1:0] hold_flat,
    input  logic [FLAG_BITS-1:0]     flags,
    output cmd_t                     cmd,
    output logic [REG_W-1:0]         rdata
);
    localparam int STRIDE_SH = $clog2(CNT_STRIDE);

    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } rif_st_t;

    rif_st_t            s_d, s_q;
    logic [ADDR_W-1:0]  off;
    logic [ADDR_W-1:0]  idx;
    logic [STRIDE_SH-1:0] word;
    logic [CNT_W-1:0]   cnt_val;
    logic [PAD_W-1:0]   padded;
    logic [REG_W-1:0]   cword;
    logic [REG_W-1:0]   fword;
    logic               idx_hit;
    logic               word_hit;
    logic               in_cnt;
    logic               in_flag;
    logic               mapped;
    logic               unused_wdata;

    assign unused_wdata = ^wdata[REG_W-1:CLR_BIT+1];

    always_comb begin
        cmd      = '0;
        in_flag  = 1'b0;
        fword    = '0;
        for (int j = 0; j < FLAG_REGS; j++) begin
            if (addr == ADDR_W'(FLAG_BASE + j)) begin
                in_flag       = 1'b1;
                fword         = flags[j*REG_W +: REG_W];
                cmd.flag_rd[j] = rd;
            end
        end
        cmd.snap = wr && (addr == ADDR_W'(CTRL_ADDR)) && wdata[SNAP_BIT];
        cmd.clr  = wr && (addr == ADDR_W'(CTRL_ADDR)) && wdata[CLR_BIT];

        off     = addr - ADDR_W'(CNT_BASE);
        idx     = off >> STRIDE_SH;
        word    = off[STRIDE_SH-1:0];
        cnt_val = '0;
        idx_hit = 1'b0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (idx == ADDR_W'(i)) begin
                cnt_val = hold_flat[i*CNT_W +: CNT_W];
                idx_hit = 1'b1;
            end
        end
        padded   = {{(PAD_W-CNT_W){1'b0}}, cnt_val};
        cword    = '0;
        word_hit = 1'b0;
        for (int w = 0; w < CNT_WORDS; w++) begin
            if (word == STRIDE_SH'(w)) begin
                cword    = padded[w*REG_W +: REG_W];
                word_hit = 1'b1;
            end
        end
        in_cnt = (addr >= ADDR_W'(CNT_BASE)) && idx_hit && word_hit;
        mapped = in_cnt || in_flag;

        s_d = s_q;
        if (rd) begin
            if (in_flag) begin
                s_d.rdata = fword;
            end else if (in_cnt) begin
                s_d.rdata = cword;
            end else begin
                s_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;

    a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !mapped) |=> (s_q.rdata == '0));
    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(s_q.rdata));
    a_r6_one_flag_reg_read: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> $onehot0(cmd.flag_rd));
endmodule

// File: rtl/stat_snapshot_bank.sv
module stat_snapshot_bank
    import stat_pkg::*;
#(
    parameter int NUM_CNT = 24,
    parameter int CNT_W   = 40,
    parameter int AMT_W   = 5,
    parameter int ADDR_W  = 8,
    parameter logic [NUM_CNT-1:0] OCTET_MASK =
        NUM_CNT'(1) | (NUM_CNT'(1) << (NUM_CNT / 2))
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CNT-1:0]       evt_inc,
    input  logic [NUM_CNT*AMT_W-1:0] evt_amt,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_wr,
    input  logic [15:0]              reg_wdata,
    input  logic                     reg_rd,
    output logic [15:0]              reg_rdata
);
    cmd_t                     cmd;
    logic [NUM_CNT*CNT_W-1:0] hold_flat;
    logic [NUM_CNT-1:0]       wrap;
    logic [FLAG_BITS-1:0]     flags;

    stat_regif #(
        .NUM_CNT(NUM_CNT),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .rd       (reg_rd),
        .hold_flat(hold_flat),
        .flags    (flags),
        .cmd      (cmd),
        .rdata    (reg_rdata)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_ctr
        stat_ctr #(
            .CNT_W   (CNT_W),
            .AMT_W   (AMT_W),
            .IS_OCTET(OCTET_MASK[g])
        ) u_ctr (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (cmd.clr),
            .snap (cmd.snap),
            .inc  (evt_inc[g]),
            .amt  (evt_amt[g*AMT_W +: AMT_W]),
            .hold (hold_flat[g*CNT_W +: CNT_W]),
            .wrap (wrap[g])
        );
    end

    stat_flags #(
        .NUM_CNT(NUM_CNT)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .flag_rd(cmd.flag_rd),
        .flags  (flags)
    );

    a_r10_reset_rdata_zero: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0));
endmodule

// File: tb/stat_snapshot_bank_test.sv
module stat_snapshot_bank_test;
    localparam int  N    = 6;
    localparam int  CW   = 18;
    localparam int  AW   = 5;
    localparam longint MOD = longint'(1) << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_inc = '0;
    logic [N*AW-1:0] evt_amt = '0;
    logic [7:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic          reg_rd = 1'b0;
    logic [15:0]   reg_rdata;

    int     checks = 0;
    int     fails = 0;
    bit     done = 1'b0;
    longint live_m [N];
    longint hold_m [N];

    always #2.5 clk = ~clk;

    stat_snapshot_bank #(
        .NUM_CNT(N), .CNT_W(CW), .AMT_W(AW), .ADDR_W(8),
        .OCTET_MASK(6'b000011)
    ) uut (
        .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .evt_amt(evt_amt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic snap();
        wr(8'h00, 16'h0001);
        for (int i = 0; i < N; i++) hold_m[i] = live_m[i];
    endtask

    task automatic read_cnt(input int i, input string req);
        logic [15:0] d;
        rd(8'(16 + 4*i), d);
        chk(req, longint'(d), hold_m[i] & 64'hFFFF);
        rd(8'(16 + 4*i + 1), d);
        chk(req, longint'(d), (hold_m[i] >> 16) & 64'hFFFF);
        rd(8'(16 + 4*i + 2), d);
        chk(req, longint'(d), (hold_m[i] >> 32) & 64'hFF);
    endtask

    task automatic step(input logic [N-1:0] inc, input logic [N*AW-1:0] amts);
        evt_inc = inc; evt_amt = amts;
        for (int i = 0; i < N; i++) begin
            if (inc[i]) begin
                live_m[i] = (live_m[i] + ((i < 2) ? longint'(amts[i*AW +: AW]) : 1)) % MOD;
            end
        end
        @(negedge clk);
        evt_inc = '0; evt_amt = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [N*AW-1:0] amts;
        logic [N-1:0] inc;
        for (int i = 0; i < N; i++) begin live_m[i] = 0; hold_m[i] = 0; end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 rdata after reset", longint'(reg_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < N; i++) read_cnt(i, "R10 holding zero");
        for (int j = 0; j < 4; j++) begin
            rd(8'(4 + j), d);
            chk("R10 flags zero", longint'(d), 0);
        end
        snap();
        for (int i = 0; i < N; i++) read_cnt(i, "R10 live zero");

        // R1 R2 R3: varied increment patterns
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 60; c++) begin
                for (int i = 0; i < N; i++) begin
                    amts[i*AW +: AW] = AW'(((c + r*60) * 5 + i * 3) % 17);
                    inc[i] = (((c + r*60) * 13 + i * 7 + r) % 5) != 0;
                end
                step(inc, amts);
            end
            snap();
            for (int i = 0; i < N; i++) read_cnt(i, "R1 R2 counts after pattern");
        end

        // R1: amount 16 on octet counter adds 16, on frame counter adds 1
        amts = '0;
        for (int i = 0; i < N; i++) amts[i*AW +: AW] = 5'd16;
        step('1, amts);
        snap();
        for (int i = 0; i < N; i++) read_cnt(i, "R1 max amount");

        // R3: holding registers unaffected by later increments
        step('1, amts);
        for (int i = 0; i < N; i++) read_cnt(i, "R3 holding stable");

        // R3: increment in the snapshot cycle is excluded
        snap();
        reg_addr = 8'h00; reg_wdata = 16'h0001; reg_wr = 1'b1; evt_inc = 6'b000100;
        for (int i = 0; i < N; i++) hold_m[i] = live_m[i];
        live_m[2] = live_m[2] + 1;
        @(negedge clk);
        reg_wr = 1'b0; evt_inc = '0;
        read_cnt(2, "R3 same-cycle increment excluded");
        snap();
        read_cnt(2, "R3 increment seen in next snapshot");

        // R4: clear with increments in the same cycle; holding untouched
        reg_addr = 8'h00; reg_wdata = 16'h0002; reg_wr = 1'b1; evt_inc = '1; evt_amt = amts;
        @(negedge clk);
        reg_wr = 1'b0; evt_inc = '0; evt_amt = '0;
        for (int i = 0; i < N; i++) live_m[i] = 0;
        for (int i = 0; i < N; i++) read_cnt(i, "R4 holding kept over clear");
        snap();
        for (int i = 0; i < N; i++) read_cnt(i, "R4 live zeroed");

        // R4: snapshot and clear together capture pre-clear values
        for (int c = 0; c < 7; c++) step('1, amts);
        wr(8'h00, 16'h0003);
        for (int i = 0; i < N; i++) begin hold_m[i] = live_m[i]; live_m[i] = 0; end
        for (int i = 0; i < N; i++) read_cnt(i, "R4 snap with clear pre-clear");
        snap();
        for (int i = 0; i < N; i++) read_cnt(i, "R4 zero after snap with clear");

        // R8: unmapped addresses
        rd(8'h00, d); chk("R8 control reads zero", longint'(d), 0);
        for (int a = 1; a < 4; a++) begin
            rd(8'(a), d); chk("R8 gap reads zero", longint'(d), 0);
        end
        for (int a = 8; a < 16; a++) begin
            rd(8'(a), d); chk("R8 gap reads zero", longint'(d), 0);
        end
        for (int i = 0; i < N; i++) begin
            rd(8'(16 + 4*i + 3), d); chk("R8 offset 3 reads zero", longint'(d), 0);
        end
        for (int a = 16 + 4*N; a < 256; a += 7) begin
            rd(8'(a), d); chk("R8 beyond last counter", longint'(d), 0);
        end
        rd(8'hFF, d); chk("R8 top address", longint'(d), 0);

        // R9: rdata holds without a read strobe
        rd(8'(16 + 4*0), d);
        reg_addr = 8'h05;
        repeat (3) @(negedge clk);
        chk("R9 rdata held", longint'(reg_rdata), longint'(d));

        // R5: counter 0 wraps exactly at 2^18
        amts = '0; amts[0 +: AW] = 5'd16;
        for (int c = 0; c < int'(MOD / 16); c++) step(6'b000001, amts);
        rd(8'h04, d); chk("R5 wrap sets flag 0", longint'(d), 1);
        rd(8'h04, d); chk("R6 flag cleared by read", longint'(d), 0);
        snap();
        read_cnt(0, "R5 wrapped value");

        // R7: wrap coincident with clearing read of its register
        amts = '0; amts[AW +: AW] = 5'd16;
        for (int c = 0; c < int'(MOD / 16) - 1; c++) step(6'b000010, amts);
        reg_addr = 8'h04; reg_rd = 1'b1; evt_inc = 6'b000010; evt_amt = amts;
        @(negedge clk);
        reg_rd = 1'b0; evt_inc = '0; evt_amt = '0;
        live_m[1] = 0;
        chk("R7 read returns earlier flags", longint'(reg_rdata), 0);
        rd(8'h04, d); chk("R7 flag 1 survives", longint'(d), 2);
        rd(8'h04, d); chk("R6 flag cleared after read", longint'(d), 0);
        for (int j = 1; j < 4; j++) begin
            rd(8'(4 + j), d); chk("R6 absent counter flags zero", longint'(d), 0);
        end
        snap();
        read_cnt(1, "R5 counter 1 wrapped");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule